// File: doc/BRIEF.md
# Byte-Wide Host Register Window for a SCSI Controller Core

This block is the register front end that a host uses to reach a SCSI controller core one byte at a time. Wide 32-bit registers (data structure address, temporary, script pointer, script status and a bank of scratch words) appear as four consecutive byte offsets with the least significant byte at the lowest offset. Next to them sit the DMA and SCSI interrupt status registers, their enable masks, a control register that carries the connected and bus-reset bits, a small interrupt status register, and a few diagnostic registers that answer with fixed values.

The core sets status bits through side inputs that are ORed into the stored status. The host side is a single synchronous strobe interface: on a clock edge where `rd_en` is high the byte at `addr` is captured into `rdata`, and on an edge where `wr_en` is high `wdata` is written. Several reads change state: the status registers clear when read, a signal-process flag is handed out once and consumed, and the DMA status clear is held off while the on-the-fly interrupt flag is pending. The interrupt output is derived from the registered status, so it follows any status change by one edge.

Top module: `hba_reg_window`

## Requirements
- R1: The 32-bit registers sit at base offsets 0x10, 0x1C, 0x2C, 0x30 and 0x34; byte base+k holds bits 8k+7 down to 8k, and a byte write changes only that lane.
- R2: Scratch words 1 to 17 occupy offsets 0x5C to 0x9F; an offset selects word (offset - 0x58) / 4 and lane offset mod 4, each word independent of the others.
- R3: A read of offset 0x0C returns the DMA status with bit 7 forced to one and then clears it, except when the on-the-fly flag (bit 2 of offset 0x14) is set, in which case the value is kept.
- R4: A read of offset 0x42 or 0x43 returns that SCSI interrupt status byte and clears it; a status event arriving in the same cycle as the read survives the clear.
- R5: A read of offset 0x1A returns 0x90; when the signal-process flag (bit 5 of offset 0x14) is set, the read returns 0xD0 and clears the flag.
- R6: Offset 0x0F reads 0x00 while bit 4 (connected) of the control register at offset 0x01 is set and 0x02 otherwise.
- R7: Offsets 0x07, 0x18 and 0x52 read the fixed values 0x7F, 0xFF and 0xE0.
- R8: Writing offset 0x01 with bit 3 set sets bit 1 of the bus status at 0x0D and bit 1 of the SCSI interrupt status at 0x42; a write with bit 3 clear clears bit 1 of 0x0D; bit 5 of the written byte is never stored.
- R9: `irq` is high exactly when the DMA status ANDed with the enable at 0x39, or a SCSI status ANDed with its enable at 0x40 or 0x41, is non-zero, or the on-the-fly flag is set; it reflects the status one edge after the change.
- R10: A read of an unmapped offset returns 0x00 and changes no state.
- R11: After reset every register is zero, `rdata` is 0x00 and `irq` is low.
- R12: At offset 0x14, writing bit 2 as one clears the on-the-fly flag and writing bit 5 as one sets the signal-process flag; the inputs `fly_set` and `sigp_set` set the same flags, and a set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe for the byte at `addr` |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | 8 | Byte offset |
| wdata | input | 8 | Write data |
| dma_evt | input | 8 | Core events ORed into DMA status |
| sint0_evt | input | 8 | Core events ORed into SCSI status 0 |
| sint1_evt | input | 8 | Core events ORed into SCSI status 1 |
| fly_set | input | 1 | Sets the on-the-fly interrupt flag |
| sigp_set | input | 1 | Sets the signal-process flag |
| rdata | output | 8 | Read data, valid after the read edge |
| irq | output | 1 | Interrupt request |

## Verification
A wrong status bit shows on `irq` in the very next cycle whenever its enable is set, and on the following read of its status offset, where the bench compares the whole byte. A missed or extra clear-on-read is exposed by a second back-to-back read, which must return the cleared or the retained value. A lane write that leaks into a neighbour byte or word appears on the read-back sweep of every lane of the wide registers.

// File: rtl/hba_reg_pkg.sv
package hba_reg_pkg;

    localparam int ADDR_W = 8;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTL1,
        SEL_GPFIX,
        SEL_DSTAT,
        SEL_BUSST,
        SEL_LINK,
        SEL_ISTAT,
        SEL_DIAG0,
        SEL_DIAG2,
        SEL_DIEN,
        SEL_SIEN0,
        SEL_SIEN1,
        SEL_SIST0,
        SEL_SIST1,
        SEL_DIAG4
    } sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctl1;
        logic [BYTE_W-1:0] busst;
        logic [BYTE_W-1:0] dstat;
        logic [BYTE_W-1:0] dien;
        logic [BYTE_W-1:0] sist0;
        logic [BYTE_W-1:0] sist1;
        logic [BYTE_W-1:0] sien0;
        logic [BYTE_W-1:0] sien1;
        logic              fly;
        logic              sigp;
    } stat_t;

    // control register bits
    localparam int CTL1_RST_BIT  = 3;
    localparam int CTL1_CON_BIT  = 4;
    localparam int CTL1_SEQ_BIT  = 5;
    // interrupt status register bits
    localparam int ISTAT_FLY_BIT  = 2;
    localparam int ISTAT_SIGP_BIT = 5;
    // bit raised by a bus reset in bus status and SCSI status 0
    localparam int BUS_RST_BIT = 1;

endpackage

// File: rtl/hba_addr_decode.sv
module hba_addr_decode
    import hba_reg_pkg::*;
#(
    parameter int NUM_SCRATCH = 18,
    localparam int NUM_WIDE = NUM_SCRATCH + 4,
    localparam int IDX_W = $clog2(NUM_WIDE)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              wide_hit,
    output logic [IDX_W-1:0]  wide_idx,
    output sel_e              sel
);

    function automatic logic [ADDR_W-1:0] wide_base(input int i);
        case (i)
            0:       return 8'h10;
            1:       return 8'h1C;
            2:       return 8'h2C;
            3:       return 8'h30;
            4:       return 8'h34;
            default: return ADDR_W'(8'h58 + 4 * (i - 4));
        endcase
    endfunction

    logic [NUM_WIDE-1:0] hit_vec;

    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_hit
        localparam logic [ADDR_W-1:0] BASE = wide_base(g);
        assign hit_vec[g] = (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    end

    always_comb begin
        wide_hit = |hit_vec;
        wide_idx = '0;
        for (int i = 0; i < NUM_WIDE; i++) begin
            if (hit_vec[i]) wide_idx = IDX_W'(i);
        end
    end

    always_comb begin
        case (addr)
            8'h01:   sel = SEL_CTL1;
            8'h07:   sel = SEL_GPFIX;
            8'h0C:   sel = SEL_DSTAT;
            8'h0D:   sel = SEL_BUSST;
            8'h0F:   sel = SEL_LINK;
            8'h14:   sel = SEL_ISTAT;
            8'h18:   sel = SEL_DIAG0;
            8'h1A:   sel = SEL_DIAG2;
            8'h39:   sel = SEL_DIEN;
            8'h40:   sel = SEL_SIEN0;
            8'h41:   sel = SEL_SIEN1;
            8'h42:   sel = SEL_SIST0;
            8'h43:   sel = SEL_SIST1;
            8'h52:   sel = SEL_DIAG4;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/hba_wide_bank.sv
module hba_wide_bank
    import hba_reg_pkg::*;
#(
    parameter int NUM_WIDE = 22,
    localparam int IDX_W = $clog2(NUM_WIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        lane,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [NUM_WIDE-1:0][31:0] regs_d, regs_q;

    always_comb begin
        regs_d  = regs_q;
        rd_byte = '0;
        if (hit) begin
            rd_byte = regs_q[idx][{lane, 3'b000} +: BYTE_W];
            if (wr_en) regs_d[idx][{lane, 3'b000} +: BYTE_W] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

endmodule

// File: rtl/hba_irq_status.sv
module hba_irq_status
    import hba_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  sel_e              sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] dma_evt,
    input  logic [BYTE_W-1:0] sint0_evt,
    input  logic [BYTE_W-1:0] sint1_evt,
    input  logic              fly_set,
    input  logic              sigp_set,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              irq
);

    stat_t st_d, st_q;

    // next state: host writes, then read side effects, then core events
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_CTL1: begin
                    st_d.ctl1 = wdata;
                    st_d.ctl1[CTL1_SEQ_BIT] = 1'b0;
                    if (wdata[CTL1_RST_BIT]) begin
                        st_d.busst[BUS_RST_BIT] = 1'b1;
                        st_d.sist0[BUS_RST_BIT] = 1'b1;
                    end else begin
                        st_d.busst[BUS_RST_BIT] = 1'b0;
                    end
                end
                SEL_ISTAT: begin
                    if (wdata[ISTAT_FLY_BIT])  st_d.fly  = 1'b0;
                    if (wdata[ISTAT_SIGP_BIT]) st_d.sigp = 1'b1;
                end
                SEL_DIEN:  st_d.dien  = wdata;
                SEL_SIEN0: st_d.sien0 = wdata;
                SEL_SIEN1: st_d.sien1 = wdata;
                default: ;
            endcase
        end
        if (rd_en) begin
            case (sel)
                SEL_DSTAT: if (!st_q.fly) st_d.dstat = '0;
                SEL_SIST0: st_d.sist0 = '0;
                SEL_SIST1: st_d.sist1 = '0;
                SEL_DIAG2: st_d.sigp  = 1'b0;
                default: ;
            endcase
        end
        st_d.dstat = st_d.dstat | dma_evt;
        st_d.sist0 = st_d.sist0 | sint0_evt;
        st_d.sist1 = st_d.sist1 | sint1_evt;
        if (fly_set)  st_d.fly  = 1'b1;
        if (sigp_set) st_d.sigp = 1'b1;
    end

    // read value from registered state
    always_comb begin
        rd_byte = '0;
        case (sel)
            SEL_CTL1:  rd_byte = st_q.ctl1;
            SEL_GPFIX: rd_byte = 8'h7F;
            SEL_DSTAT: rd_byte = st_q.dstat | 8'h80;
            SEL_BUSST: rd_byte = st_q.busst;
            SEL_LINK:  rd_byte = st_q.ctl1[CTL1_CON_BIT] ? 8'h00 : 8'h02;
            SEL_ISTAT: begin
                rd_byte[ISTAT_FLY_BIT]  = st_q.fly;
                rd_byte[ISTAT_SIGP_BIT] = st_q.sigp;
            end
            SEL_DIAG0: rd_byte = 8'hFF;
            SEL_DIAG2: rd_byte = st_q.sigp ? 8'hD0 : 8'h90;
            SEL_DIEN:  rd_byte = st_q.dien;
            SEL_SIEN0: rd_byte = st_q.sien0;
            SEL_SIEN1: rd_byte = st_q.sien1;
            SEL_SIST0: rd_byte = st_q.sist0;
            SEL_SIST1: rd_byte = st_q.sist1;
            SEL_DIAG4: rd_byte = 8'hE0;
            default:   rd_byte = '0;
        endcase
    end

    assign irq = (|(st_q.dstat & st_q.dien)) | (|(st_q.sist0 & st_q.sien0)) |
                 (|(st_q.sist1 & st_q.sien1)) | st_q.fly;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/hba_reg_window.sv
module hba_reg_window
    import hba_reg_pkg::*;
#(
    parameter int NUM_SCRATCH = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] dma_evt,
    input  logic [BYTE_W-1:0] sint0_evt,
    input  logic [BYTE_W-1:0] sint1_evt,
    input  logic              fly_set,
    input  logic              sigp_set,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq
);

    localparam int NUM_WIDE = NUM_SCRATCH + 4;
    localparam int IDX_W    = $clog2(NUM_WIDE);

    logic              wide_hit;
    logic [IDX_W-1:0]  wide_idx;
    sel_e              sel;
    logic [BYTE_W-1:0] wide_byte, stat_byte;
    logic [BYTE_W-1:0] rdata_d, rdata_q;

    hba_addr_decode #(.NUM_SCRATCH(NUM_SCRATCH)) u_dec (
        .addr     (addr),
        .wide_hit (wide_hit),
        .wide_idx (wide_idx),
        .sel      (sel)
    );

    hba_wide_bank #(.NUM_WIDE(NUM_WIDE)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .hit     (wide_hit),
        .idx     (wide_idx),
        .lane    (addr[1:0]),
        .wdata   (wdata),
        .rd_byte (wide_byte)
    );

    hba_irq_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .sel       (sel),
        .wdata     (wdata),
        .dma_evt   (dma_evt),
        .sint0_evt (sint0_evt),
        .sint1_evt (sint1_evt),
        .fly_set   (fly_set),
        .sigp_set  (sigp_set),
        .rd_byte   (stat_byte),
        .irq       (irq)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) rdata_d = wide_hit ? wide_byte : stat_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hba_reg_window_chk.sv
module hba_reg_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [7:0] addr,
    input logic       fly_set,
    input logic [7:0] rdata,
    input logic       irq
);

    a_r3_dstat_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h0C) |=> rdata[7]);

    a_r5_diag2_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h1A) |=> ((rdata & 8'hBF) == 8'h90));

    a_r6_link_values: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h0F) |=> (rdata == 8'h00 || rdata == 8'h02));

    a_r7_fixed_gp: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h07) |=> (rdata == 8'h7F));

    a_r7_fixed_diag4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h52) |=> (rdata == 8'hE0));

    a_r9_fly_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        fly_set |=> irq);

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 8'h08 || addr == 8'hA0)) |=> (rdata == 8'h00));

endmodule

bind hba_reg_window hba_reg_window_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .fly_set (fly_set),
    .rdata   (rdata),
    .irq     (irq)
);

// File: tb/hba_reg_window_test.sv
module hba_reg_window_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] dma_evt = 8'h00;
    logic [7:0] sint0_evt = 8'h00;
    logic [7:0] sint1_evt = 8'h00;
    logic       fly_set = 1'b0;
    logic       sigp_set = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit fire = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] a;
        string      req;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    hba_reg_window uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .dma_evt(dma_evt), .sint0_evt(sint0_evt),
        .sint1_evt(sint1_evt), .fly_set(fly_set), .sigp_set(sigp_set),
        .rdata(rdata), .irq(irq)
    );

    // monitor: a read strobed at an edge is compared at the following falling edge
    always @(posedge clk) fire <= rd_en;

    always @(negedge clk) begin
        if (fire) begin
            item_t it;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %02h expected none", rdata);
            end else begin
                it = sb.pop_front();
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s read %02h: actual %02h expected %02h",
                             it.req, it.a, rdata, it.exp);
                end
            end
        end
    end

    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        sb.push_back('{exp: exp, a: a, req: req});
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] de, input logic [7:0] s0, input logic [7:0] s1,
                         input logic fs, input logic ss);
        @(negedge clk);
        dma_evt = de; sint0_evt = s0; sint1_evt = s1; fly_set = fs; sigp_set = ss;
        @(negedge clk);
        dma_evt = '0; sint0_evt = '0; sint1_evt = '0; fly_set = 1'b0; sigp_set = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string req);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq: actual %0b expected %0b", req, irq, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (rdata !== 8'h00) begin
            errors++;
            $display("FAIL R11 rdata: actual %02h expected 00", rdata);
        end
        chk_irq(1'b0, "R11");
        rst_n = 1'b1;
        do_read(8'h39, 8'h00, "R11");
        do_read(8'h14, 8'h00, "R11");

        // R1: lanes of a wide register
        do_write(8'h10, 8'h11); do_write(8'h11, 8'h22);
        do_write(8'h12, 8'h33); do_write(8'h13, 8'h44);
        do_read(8'h10, 8'h11, "R1"); do_read(8'h11, 8'h22, "R1");
        do_read(8'h12, 8'h33, "R1"); do_read(8'h13, 8'h44, "R1");
        do_write(8'h12, 8'hAB);
        do_read(8'h10, 8'h11, "R1"); do_read(8'h11, 8'h22, "R1");
        do_read(8'h12, 8'hAB, "R1"); do_read(8'h13, 8'h44, "R1");
        do_write(8'h33, 8'h5A);
        do_read(8'h30, 8'h00, "R1"); do_read(8'h32, 8'h00, "R1");
        do_read(8'h33, 8'h5A, "R1"); do_read(8'h1F, 8'h00, "R1");
        do_write(8'h34, 8'hC3);
        do_read(8'h34, 8'hC3, "R1");

        // R2: upper scratch words
        for (int k = 0; k < 17; k++)
            do_write(8'h5C + 8'(4 * k) + 8'(k % 4), 8'h80 + 8'(k));
        for (int k = 0; k < 17; k++) begin
            do_read(8'h5C + 8'(4 * k) + 8'(k % 4), 8'h80 + 8'(k), "R2");
            do_read(8'h5C + 8'(4 * k) + 8'((k + 1) % 4), 8'h00, "R2");
        end
        do_write(8'h9F, 8'h77);
        do_read(8'h9F, 8'h77, "R2");
        do_read(8'h9C, 8'h90, "R2");
        do_read(8'h34, 8'hC3, "R2");

        // R10: unmapped offsets
        do_write(8'h08, 8'h55);
        do_read(8'h08, 8'h00, "R10");
        do_read(8'hA0, 8'h00, "R10");
        do_read(8'hFF, 8'h00, "R10");

        // R7: fixed values
        do_read(8'h07, 8'h7F, "R7");
        do_read(8'h18, 8'hFF, "R7");
        do_read(8'h52, 8'hE0, "R7");

        // R6: link status from connected bit
        do_read(8'h0F, 8'h02, "R6");
        do_write(8'h01, 8'h10);
        do_read(8'h0F, 8'h00, "R6");
        do_read(8'h01, 8'h10, "R6");

        // R8: bus reset bit and start bit in control register
        do_write(8'h01, 8'h28);
        do_read(8'h01, 8'h08, "R8");
        do_read(8'h0D, 8'h02, "R8");
        do_read(8'h42, 8'h02, "R8");
        do_read(8'h42, 8'h00, "R4");
        do_write(8'h01, 8'h00);
        do_read(8'h0D, 8'h00, "R8");
        do_read(8'h0F, 8'h02, "R6");

        // R3: DMA status clear on read, held while on-the-fly flag is set
        pulse(8'h05, 8'h00, 8'h00, 1'b0, 1'b0);
        do_read(8'h0C, 8'h85, "R3");
        do_read(8'h0C, 8'h80, "R3");
        pulse(8'h03, 8'h00, 8'h00, 1'b1, 1'b0);
        do_read(8'h0C, 8'h83, "R3");
        do_read(8'h0C, 8'h83, "R3");
        do_read(8'h14, 8'h04, "R12");
        do_write(8'h14, 8'h04);
        do_read(8'h14, 8'h00, "R12");
        do_read(8'h0C, 8'h83, "R3");
        do_read(8'h0C, 8'h80, "R3");

        // R5 / R12: signal-process flag consumed by diagnostic read
        do_read(8'h1A, 8'h90, "R5");
        do_write(8'h14, 8'h20);
        do_read(8'h14, 8'h20, "R12");
        do_read(8'h1A, 8'hD0, "R5");
        do_read(8'h1A, 8'h90, "R5");
        do_read(8'h14, 8'h00, "R12");
        pulse(8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
        do_read(8'h1A, 8'hD0, "R5");

        // R4: SCSI status clear on read, same-cycle event survives
        pulse(8'h00, 8'h00, 8'h81, 1'b0, 1'b0);
        do_read(8'h43, 8'h81, "R4");
        do_read(8'h43, 8'h00, "R4");
        @(negedge clk);
        sb.push_back('{exp: 8'h00, a: 8'h42, req: "R4"});
        rd_en = 1'b1; addr = 8'h42; sint0_evt = 8'h40;
        @(negedge clk);
        rd_en = 1'b0; sint0_evt = 8'h00;
        do_read(8'h42, 8'h40, "R4");

        // R9: masked interrupt
        chk_irq(1'b0, "R9");
        pulse(8'h04, 8'h00, 8'h00, 1'b0, 1'b0);
        chk_irq(1'b0, "R9");
        do_write(8'h39, 8'h04);
        chk_irq(1'b1, "R9");
        do_read(8'h0C, 8'h84, "R9");
        chk_irq(1'b0, "R9");
        do_write(8'h41, 8'h02);
        pulse(8'h00, 8'h00, 8'h01, 1'b0, 1'b0);
        chk_irq(1'b0, "R9");
        pulse(8'h00, 8'h00, 8'h02, 1'b0, 1'b0);
        chk_irq(1'b1, "R9");
        do_read(8'h43, 8'h03, "R9");
        chk_irq(1'b0, "R9");
        do_write(8'h40, 8'h02);
        do_write(8'h01, 8'h08);
        chk_irq(1'b1, "R9");
        do_read(8'h42, 8'h02, "R9");
        chk_irq(1'b0, "R9");
        pulse(8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
        chk_irq(1'b1, "R9");
        do_write(8'h14, 8'h04);
        chk_irq(1'b0, "R12");

        @(negedge clk);
        @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule